// File: doc/BRIEF.md
# SDRAM Mode-Register Write Translator

This block sits between a processor write bus and the command pins of one or two SDRAM devices. The processor sets an SDRAM mode register by writing to an address, not by sending data. A word-size write that falls in one of two reserved 4 KB address windows becomes a single Mode Register Set command. In that command the chip select of the matching area, RAS, CAS and the write enable are all driven low together, and the low twelve bits of the write address appear on the SDRAM address pins. The value on the data bus plays no part in the command.

Before the command goes out, the block decodes the address offset. The offset is the mode value shifted left by one bit on a 16-bit data bus and by two bits on a 32-bit data bus. Only sequential wrap, burst length 1 and a CAS latency of 2 or 3 are accepted, and the write policy may be single or burst. A legal setting is stored for its area and kept on registered outputs so that later command sequencing can use it. An access that is not word-size, or an offset outside the supported set, produces a one-cycle error pulse and no command. After each command, a busy flag shows that the command slot is taken for a configurable settling delay.

Top module: `sdram_mrs_xlate`

## Requirements
- R1: A write with `wr_addr[31:12]` = 0xA4FD4 selects area 2 and drives `sd_cs_n[0]` low. A write with 0xA4FD5 selects area 3 and drives `sd_cs_n[1]` low. In the cycle after the accepting clock edge, the block drives exactly one chip select low for one cycle, and `sd_ras_n`, `sd_cas_n` and `sd_we_n` are low in that same cycle.
- R2: During a command, `sd_addr[11:0]` carries `wr_addr[11:0]` and every address pin from bit 12 up is 0. Outside a command, all address pins are 0 and all command pins are high.
- R3: The value of `wr_data` has no effect on the command, the error output or the stored settings.
- R4: `wr_size` encodes 2'b00 byte, 2'b01 word and 2'b10 longword. An accepted window write whose size is not 2'b01 issues no command and raises `mrs_err` for one cycle.
- R5: With `cfg_wide`=0 (16-bit bus), the offsets 0x440, 0x460, 0x040 and 0x060 give (CL2, single write), (CL3, single write), (CL2, burst write) and (CL3, burst write).
- R6: With `cfg_wide`=1 (32-bit bus), the same four settings use the offsets 0x880, 0x8C0, 0x080 and 0x0C0.
- R7: Any other offset within an accepted window write issues no command and raises `mrs_err` for one cycle. This includes an offset that is legal only for the other bus width.
- R8: While `cfg_done` is 0, window writes issue no command and raise no error.
- R9: `busy` is high for MRS_DLY+1 cycles, starting in the command cycle. A window write sampled while `busy` is high issues no command, raises no error and changes no stored setting.
- R10: Each area stores its own settings. `cas_lat2`/`cas_lat3` hold the latency as the value 2 or 3, and `burst_wr2`/`burst_wr3` read 1 for burst write and 0 for single write. Both are updated in the command cycle. After reset they read 2 and 0.
- R11: A write outside both windows issues no command, raises no error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Controller configured; enables mode writes |
| cfg_wide | input | 1 | 1 = 32-bit data bus layout, 0 = 16-bit |
| wr_valid | input | 1 | Write request this cycle |
| wr_addr | input | 32 | Write address |
| wr_size | input | 2 | Access size (00 byte, 01 word, 10 longword) |
| wr_data | input | 32 | Write data (ignored) |
| sd_cs_n | output | 2 | Chip selects, bit 0 area 2, bit 1 area 3 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | SDA_W | SDRAM address pins |
| mrs_err | output | 1 | One-cycle error pulse for a rejected mode write |
| busy | output | 1 | Command slot taken |
| cas_lat2 | output | 2 | Stored CAS latency, area 2 |
| cas_lat3 | output | 2 | Stored CAS latency, area 3 |
| burst_wr2 | output | 1 | Stored write-burst policy, area 2 |
| burst_wr3 | output | 1 | Stored write-burst policy, area 3 |

## Verification
The command pins, the address pins, the error pulse and the stored settings all change one cycle after the clock edge that samples the write. `busy` rises in that same cycle and stays high for MRS_DLY+1 cycles. The bench's behavioural model computes the expected values at the same edge that the design registers its outputs. Both are compared at the following falling edge, so each result is checked in the exact cycle it becomes due, and a write sampled during the busy window must leave every output unchanged. The model decodes offsets with a lookup of the allowed address list, not with the design's field arithmetic.

// File: rtl/sdram_mrs_xlate.sv
module sdram_mrs_xlate #(
  parameter int          SDA_W   = 15,
  parameter int          MRS_DLY = 2,
  parameter logic [19:0] WIN2    = 20'hA4FD4,
  parameter logic [19:0] WIN3    = 20'hA4FD5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic             cfg_wide,
  input  logic             wr_valid,
  input  logic [31:0]      wr_addr,
  input  logic [1:0]       wr_size,
  input  logic [31:0]      wr_data,
  output logic [1:0]       sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [SDA_W-1:0] sd_addr,
  output logic             mrs_err,
  output logic             busy,
  output logic [1:0]       cas_lat2,
  output logic [1:0]       cas_lat3,
  output logic             burst_wr2,
  output logic             burst_wr3
);
  localparam int CW = $clog2(MRS_DLY + 2);
  localparam logic [CW-1:0] LOAD = CW'(MRS_DLY + 1);

  logic [CW-1:0] cnt;
  logic [11:0]   mode;
  logic          aligned;

  wire unused_data = ^wr_data;
  wire [11:0] off  = wr_addr[11:0];
  wire hit2  = wr_valid && (wr_addr[31:12] == WIN2);
  wire hit3  = wr_valid && (wr_addr[31:12] == WIN3);
  wire take  = (hit2 || hit3) && cfg_done && !busy;
  wire word  = (wr_size == 2'b01);

  always_comb begin
    if (cfg_wide) begin
      mode    = {2'b00, off[11:2]};
      aligned = (off[1:0] == 2'b00);
    end else begin
      mode    = {1'b0, off[11:1]};
      aligned = !off[0];
    end
  end

  wire cl_ok = (mode[6:4] == 3'd2) || (mode[6:4] == 3'd3);
  wire legal = aligned && (mode[2:0] == 3'd0) && !mode[3] && cl_ok &&
               (mode[8:7] == 2'b00) && (mode[11:10] == 2'b00);
  wire issue = take && word && legal;
  wire bad   = take && !(word && legal);

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_cs_n   <= 2'b11;
      sd_ras_n  <= 1'b1;
      sd_cas_n  <= 1'b1;
      sd_we_n   <= 1'b1;
      sd_addr   <= '0;
      mrs_err   <= 1'b0;
      cnt       <= '0;
      cas_lat2  <= 2'd2;
      cas_lat3  <= 2'd2;
      burst_wr2 <= 1'b0;
      burst_wr3 <= 1'b0;
    end else begin
      sd_cs_n  <= {!(issue && hit3), !(issue && hit2)};
      sd_ras_n <= !issue;
      sd_cas_n <= !issue;
      sd_we_n  <= !issue;
      sd_addr  <= issue ? SDA_W'(off) : '0;
      mrs_err  <= bad;
      if (issue)     cnt <= LOAD;
      else if (busy) cnt <= cnt - 1'b1;
      if (issue && hit2) begin
        cas_lat2  <= {1'b1, mode[4]};
        burst_wr2 <= !mode[9];
      end
      if (issue && hit3) begin
        cas_lat3  <= {1'b1, mode[4]};
        burst_wr3 <= !mode[9];
      end
    end
  end
endmodule

module sdram_mrs_xlate_chk #(
  parameter int SDA_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_done,
  input logic [1:0]       sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [SDA_W-1:0] sd_addr,
  input logic             mrs_err,
  input logic             busy,
  input logic [1:0]       cas_lat2,
  input logic [1:0]       cas_lat3
);
  wire cmd = (sd_cs_n != 2'b11);

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~sd_cs_n)); // R1
  AST_CMD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) cmd |-> (!sd_ras_n && !sd_cas_n && !sd_we_n)); // R1
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n) !cmd |-> (sd_ras_n && sd_cas_n && sd_we_n && sd_addr == '0)); // R2
  AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cmd |-> (sd_addr >> 12) == '0); // R2
  AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n) mrs_err |-> !cmd); // R4
  AST_NO_CMD_UNCFG: assert property (@(posedge clk) disable iff (!rst_n) !cfg_done |=> !cmd && !mrs_err); // R8
  AST_BUSY_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n) cmd |-> busy); // R9
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) cmd |=> !cmd && busy); // R9
  AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (cas_lat2 inside {2'd2, 2'd3}) && (cas_lat3 inside {2'd2, 2'd3})); // R10
endmodule

bind sdram_mrs_xlate sdram_mrs_xlate_chk #(.SDA_W(SDA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr), .mrs_err(mrs_err), .busy(busy),
  .cas_lat2(cas_lat2), .cas_lat3(cas_lat3)
);

// File: tb/sdram_mrs_xlate_test.sv
module sdram_mrs_xlate_test;
  localparam int SDA_W = 15;
  localparam int DLY   = 2;

  logic clk = 0, rst_n = 0, cfg_done = 0, cfg_wide = 0, wr_valid = 0;
  logic [31:0] wr_addr = 0, wr_data = 0;
  logic [1:0]  wr_size = 0;
  logic [1:0]  sd_cs_n, cas_lat2, cas_lat3;
  logic        sd_ras_n, sd_cas_n, sd_we_n, mrs_err, busy, burst_wr2, burst_wr3;
  logic [SDA_W-1:0] sd_addr;

  always #4 clk = ~clk;

  sdram_mrs_xlate #(.SDA_W(SDA_W), .MRS_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .cfg_wide(cfg_wide),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .mrs_err(mrs_err), .busy(busy),
    .cas_lat2(cas_lat2), .cas_lat3(cas_lat3), .burst_wr2(burst_wr2), .burst_wr3(burst_wr3)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int e_cs = 3, e_addr = 0, e_err = 0, e_cnt = 0;
  int e_cl2 = 2, e_cl3 = 2, e_bw2 = 0, e_bw3 = 0;

  function automatic bit lookup(input int off, input bit wide, output int cl, output int bw);
    int offs16[4] = '{'h440, 'h460, 'h040, 'h060};
    int offs32[4] = '{'h880, 'h8C0, 'h080, 'h0C0};
    int cls[4]    = '{2, 3, 2, 3};
    int bws[4]    = '{0, 0, 1, 1};
    cl = 0; bw = 0;
    for (int i = 0; i < 4; i++)
      if (off == (wide ? offs32[i] : offs16[i])) begin
        cl = cls[i]; bw = bws[i]; return 1'b1;
      end
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_cs = 3; e_addr = 0; e_err = 0; e_cnt = 0;
      e_cl2 = 2; e_cl3 = 2; e_bw2 = 0; e_bw3 = 0;
    end else begin
      int area, cl, bw;
      bit ok, was_busy;
      was_busy = (e_cnt > 0);
      area = 0;
      if (wr_valid && wr_addr[31:12] == 20'hA4FD4) area = 2;
      if (wr_valid && wr_addr[31:12] == 20'hA4FD5) area = 3;
      e_cs = 3; e_addr = 0; e_err = 0;
      if (was_busy) e_cnt--;
      if (area != 0 && cfg_done && !was_busy) begin
        ok = lookup(int'(wr_addr[11:0]), cfg_wide, cl, bw) && (wr_size == 2'b01);
        if (ok) begin
          e_cs = (area == 2) ? 2 : 1;
          e_addr = int'(wr_addr[11:0]);
          e_cnt = DLY + 1;
          if (area == 2) begin e_cl2 = cl; e_bw2 = bw; end
          else begin e_cl3 = cl; e_bw3 = bw; end
        end else e_err = 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 chip select", sd_cs_n, e_cs);
    chk("R1 strobes", {sd_ras_n, sd_cas_n, sd_we_n}, (e_cs != 3) ? 0 : 7);
    chk("R2 address", sd_addr, e_addr);
    chk("R7 error", mrs_err, e_err);
    chk("R9 busy", busy, e_cnt > 0);
    chk("R10 cl2", cas_lat2, e_cl2);
    chk("R10 cl3", cas_lat3, e_cl3);
    chk("R10 bw2", burst_wr2, e_bw2);
    chk("R10 bw3", burst_wr3, e_bw3);
  end

  task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_data = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset cl2", cas_lat2, 2);
    chk("R10 reset bw3", burst_wr3, 0);
    chk("R2 reset cs", sd_cs_n, 3);
    // R8: not configured
    wr(32'hA4FD4460, 2'b01, 0); idle(4);
    chk("R8 unconfigured cl2", cas_lat2, 2);
    cfg_done = 1;
    // R5: 16-bit table
    wr(32'hA4FD4460, 2'b01, 0); idle(4);
    chk("R5 cl3 single area2", {cas_lat2, burst_wr2}, {2'd3, 1'b0});
    wr(32'hA4FD5040, 2'b01, 0); idle(4);
    chk("R5 cl2 burst area3", {cas_lat3, burst_wr3}, {2'd2, 1'b1});
    wr(32'hA4FD5060, 2'b01, 0); idle(4);
    chk("R5 cl3 burst area3", {cas_lat3, burst_wr3}, {2'd3, 1'b1});
    // R3: data ignored
    wr(32'hA4FD4440, 2'b01, 32'hFFFF_FFFF); idle(4);
    chk("R3 data ignored", {cas_lat2, burst_wr2}, {2'd2, 1'b0});
    // R9: second write inside busy window
    wr(32'hA4FD4460, 2'b01, 0);
    wr(32'hA4FD5440, 2'b01, 0); idle(4);
    chk("R9 busy write dropped", {cas_lat3, burst_wr3}, {2'd3, 1'b1});
    // R4: size
    wr(32'hA4FD4440, 2'b00, 0); idle(2);
    wr(32'hA4FD4440, 2'b10, 0); idle(2);
    chk("R4 bad size kept cl2", cas_lat2, 3);
    // R7: unsupported offsets
    wr(32'hA4FD4450, 2'b01, 0); idle(2);
    wr(32'hA4FD44A0, 2'b01, 0); idle(2);
    wr(32'hA4FD4442, 2'b01, 0); idle(2);
    wr(32'hA4FD4880, 2'b01, 0); idle(2);
    chk("R7 rejected kept cl2", cas_lat2, 3);
    // R11: outside windows
    wr(32'hA4FD6440, 2'b01, 0); idle(2);
    wr(32'h00000440, 2'b01, 0); idle(2);
    chk("R11 outside ignored", cas_lat2, 3);
    // R6: 32-bit table
    cfg_wide = 1;
    wr(32'hA4FD58C0, 2'b01, 0); idle(4);
    chk("R6 cl3 single area3", {cas_lat3, burst_wr3}, {2'd3, 1'b0});
    wr(32'hA4FD4080, 2'b01, 0); idle(4);
    chk("R6 cl2 burst area2", {cas_lat2, burst_wr2}, {2'd2, 1'b1});
    wr(32'hA4FD40C0, 2'b01, 0); idle(4);
    chk("R6 cl3 burst area2", {cas_lat2, burst_wr2}, {2'd3, 1'b1});
    wr(32'hA4FD5880, 2'b01, 0); idle(4);
    chk("R6 cl2 single area3", {cas_lat3, burst_wr3}, {2'd2, 1'b0});
    wr(32'hA4FD4460, 2'b01, 0); idle(4);
    chk("R7 narrow offset on wide bus", cas_lat2, 3);
    idle(4);
    finish_run();
  end
endmodule